// File: doc/BRIEF.md
# Binary64 to Unsigned 64-bit Integer Converter

This block turns an IEEE 754 double-precision operand into an unsigned 64-bit integer. The caller supplies a 2-bit rounding-mode code with each operand. The block returns the integer together with two exception flags: invalid and inexact. The operand and mode are taken on a clock edge, and the result and flags are registered and appear one cycle later. The flags are per-conversion outputs. Accumulating them, or trapping on them, is left to the surrounding logic.

The datapath first classifies the operand. It then aligns the significand against the integer point. Any bits pushed below that point are collected as a round bit plus a sticky indication. The rounding increment depends on both the mode and the operand sign. Negativity is judged only after rounding. As a result, a negative value below one that rounds to zero yields zero flagged inexact. If its magnitude rounds up to one, the result is invalid.

Top module: `f64_to_u64_cvt`

## Requirements
- R1: While rst_ni is low, the result is 0 and both flags are 0.
- R2: The result and flags for an operand and mode sampled on a rising clock edge appear after that edge and stay unchanged until the next edge.
- R3: A negative operand with biased exponent (bits 62:52) above 1022 returns 0 with invalid=1 and inexact=0. This includes negative infinity and NaNs with the sign bit set.
- R4: A positive operand with biased exponent above 0x43E returns 0xFFFFFFFFFFFFFFFF with invalid=1 and inexact=0. This includes positive infinity and NaNs.
- R5: A non-negative in-range operand with no fractional part returns its exact integer value with no flags. Exponent 0x43E with an all-ones fraction returns 0xFFFFFFFFFFFFF800, with no carry out.
- R6: Mode code 00 rounds to nearest, and exact ties go to the even integer.
- R7: Mode code 11 truncates toward zero.
- R8: Mode code 10 rounds toward +infinity. A positive operand with a fraction increments the magnitude, and a negative one does not.
- R9: Mode code 01 rounds toward -infinity. A positive operand is truncated. A negative operand with a fraction has its magnitude raised, which makes it invalid.
- R10: A negative operand with magnitude below 1.0 returns 0 in every mode. If its rounded magnitude is nonzero, only invalid is set. If it rounds to zero, inexact is set when any fraction bit was nonzero.
- R11: Inexact is 1 exactly when discarded bits are nonzero and invalid is 0. The two flags are never 1 together.
- R12: Positive and negative zero return 0 with no flags. Subnormals use a zero hidden bit at unit exponent. A positive subnormal returns 0 with inexact, except under mode 10, where it returns 1 with inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 64 | Binary64 operand |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero |
| res_o | output | 64 | Unsigned integer result |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The rounding increment and the negative-range test can act in the same cycle. A negative fraction whose magnitude is rounded up must come out invalid rather than inexact, while the same fraction left unrounded must come out inexact. This collision is provoked directly: -0.5 under toward -infinity, the three sub-unity negative patterns, and a sweep of every exponent with both signs under all four modes. Each case is judged against an integer reference that works out the remainder and half-unit comparison on its own, and every result is checked against both flags.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int FP_EXP_W = 11;
  localparam int FP_MAN_W = 52;
  localparam int CVT_INT_W = 64;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/cvt_unpack.sv
module cvt_unpack #(
  parameter int EXP_W = cvt_pkg::FP_EXP_W,
  parameter int MAN_W = cvt_pkg::FP_MAN_W,
  parameter int INT_W = cvt_pkg::CVT_INT_W,
  localparam int SH_W = EXP_W + 1
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  output logic                 sign_o,
  output logic                 neg_big_o,
  output logic                 too_big_o,
  output logic [MAN_W:0]       sig_o,
  output logic                 lshift_o,
  output logic [SH_W-1:0]      lsh_o,
  output logic [SH_W-1:0]      rsh_o
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int ALIGN = BIAS + MAN_W;      // exponent where LSB weight is 1
  localparam int TOP   = BIAS + INT_W - 1;  // largest exponent that fits

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             is_sub;
  int               exp_eff;

  assign sign_o = op_i[EXP_W+MAN_W];
  assign exp_f  = op_i[EXP_W+MAN_W-1:MAN_W];
  assign frac_f = op_i[MAN_W-1:0];
  assign is_sub = (exp_f == '0);
  assign sig_o  = {~is_sub, frac_f};

  assign neg_big_o = sign_o && (int'(exp_f) >= BIAS);
  assign too_big_o = (int'(exp_f) > TOP);

  always_comb begin
    exp_eff  = is_sub ? 1 : int'(exp_f);
    lshift_o = (exp_eff >= ALIGN);
    lsh_o    = '0;
    rsh_o    = '0;
    if (lshift_o) lsh_o = SH_W'(exp_eff - ALIGN);
    else          rsh_o = SH_W'(ALIGN - exp_eff);
  end
endmodule

// File: rtl/cvt_align.sv
module cvt_align #(
  parameter int MAN_W = cvt_pkg::FP_MAN_W,
  parameter int INT_W = cvt_pkg::CVT_INT_W,
  parameter int SH_W  = cvt_pkg::FP_EXP_W + 1,
  localparam int WIDE  = 2 * INT_W,
  localparam int RSH_W = $clog2(WIDE)
) (
  input  logic [MAN_W:0]    sig_i,
  input  logic              lshift_i,
  input  logic [SH_W-1:0]   lsh_i,
  input  logic [SH_W-1:0]   rsh_i,
  output logic [INT_W-1:0]  mag_o,
  output logic [INT_W-1:0]  extra_o
);
  logic [WIDE-1:0]  base;
  logic [WIDE-1:0]  shifted;
  logic [WIDE-1:0]  lost_mask;
  logic [RSH_W-1:0] rsh_c;
  logic             lost;

  assign base = {{(INT_W-MAN_W-1){1'b0}}, sig_i, {INT_W{1'b0}}};

  always_comb begin
    if (rsh_i > SH_W'(WIDE - 1)) rsh_c = RSH_W'(WIDE - 1);
    else                         rsh_c = rsh_i[RSH_W-1:0];
    shifted   = base >> rsh_c;
    lost_mask = (WIDE'(1) << rsh_c) - WIDE'(1);
    lost      = |(base & lost_mask);
    if (lshift_i) begin
      mag_o   = INT_W'(sig_i) << lsh_i;
      extra_o = '0;
    end else begin
      mag_o   = shifted[WIDE-1:INT_W];
      extra_o = shifted[INT_W-1:0] | INT_W'(lost);  // jam lost bits into LSB
    end
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round #(
  parameter int INT_W = cvt_pkg::CVT_INT_W
) (
  input  logic [1:0]       rmode_i,
  input  logic             sign_i,
  input  logic             neg_big_i,
  input  logic             too_big_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic [INT_W-1:0] extra_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  import cvt_pkg::*;

  logic             rnd_bit, sticky, lossy, inc, tie;
  logic [INT_W-1:0] sum, rnd;

  assign rnd_bit = extra_i[INT_W-1];
  assign sticky  = |extra_i[INT_W-2:0];
  assign lossy   = rnd_bit | sticky;

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR: inc = rnd_bit;
      RM_DOWN: inc = sign_i & lossy;
      RM_UP:   inc = ~sign_i & lossy;
      default: inc = 1'b0;
    endcase
  end

  assign tie = (rmode_i == RM_NEAR) & rnd_bit & ~sticky;
  assign sum = mag_i + INT_W'(inc);
  assign rnd = {sum[INT_W-1:1], sum[0] & ~tie};

  always_comb begin
    res_o     = rnd;
    invalid_o = 1'b0;
    inexact_o = lossy;
    if (neg_big_i) begin
      res_o     = '0;
      invalid_o = 1'b1;
      inexact_o = 1'b0;
    end else if (too_big_i) begin
      res_o     = '1;
      invalid_o = 1'b1;
      inexact_o = 1'b0;
    end else if (sign_i && (rnd != '0)) begin
      res_o     = '0;
      invalid_o = 1'b1;
      inexact_o = 1'b0;
    end
  end
endmodule

// File: rtl/f64_to_u64_cvt.sv
module f64_to_u64_cvt #(
  parameter int EXP_W = cvt_pkg::FP_EXP_W,
  parameter int MAN_W = cvt_pkg::FP_MAN_W,
  parameter int INT_W = cvt_pkg::CVT_INT_W,
  localparam int FP_W = EXP_W + MAN_W + 1,
  localparam int SH_W = EXP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FP_W-1:0]  op_i,
  input  logic [1:0]       rmode_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  logic             sign, neg_big, too_big, lshift;
  logic [MAN_W:0]   sig;
  logic [SH_W-1:0]  lsh, rsh;
  logic [INT_W-1:0] mag, extra, res_d;
  logic             inv_d, inx_d;

  cvt_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_unpack (
    .op_i(op_i), .sign_o(sign), .neg_big_o(neg_big), .too_big_o(too_big),
    .sig_o(sig), .lshift_o(lshift), .lsh_o(lsh), .rsh_o(rsh)
  );

  cvt_align #(.MAN_W(MAN_W), .INT_W(INT_W), .SH_W(SH_W)) u_align (
    .sig_i(sig), .lshift_i(lshift), .lsh_i(lsh), .rsh_i(rsh),
    .mag_o(mag), .extra_o(extra)
  );

  cvt_round #(.INT_W(INT_W)) u_round (
    .rmode_i(rmode_i), .sign_i(sign), .neg_big_i(neg_big), .too_big_i(too_big),
    .mag_i(mag), .extra_i(extra),
    .res_o(res_d), .invalid_o(inv_d), .inexact_o(inx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= inv_d;
      inexact_o <= inx_d;
    end
  end
endmodule

// File: rtl/cvt_checker.sv
module cvt_checker #(
  parameter int EXP_W = cvt_pkg::FP_EXP_W,
  parameter int MAN_W = cvt_pkg::FP_MAN_W,
  parameter int INT_W = cvt_pkg::CVT_INT_W,
  localparam int FP_W = EXP_W + MAN_W + 1,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int TOP  = BIAS + INT_W - 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [FP_W-1:0]  op_i,
  input logic [1:0]       rmode_i,
  input logic [INT_W-1:0] res_o,
  input logic             invalid_o,
  input logic             inexact_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  logic             p_sign;
  logic [EXP_W-1:0] p_exp;
  logic [FP_W-2:0]  p_mag;
  assign p_sign = op_i[FP_W-1];
  assign p_exp  = op_i[FP_W-2:MAN_W];
  assign p_mag  = op_i[FP_W-2:0];

  assert_rst_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (res_o == '0 && !invalid_o && !inexact_o));

  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(invalid_o && inexact_o));

  assert_neg_big_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(p_sign) && (int'($past(p_exp)) >= BIAS)
    |-> (res_o == '0 && invalid_o && !inexact_o));

  assert_pos_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && !$past(p_sign) && (int'($past(p_exp)) > TOP)
    |-> (res_o == '1 && invalid_o));

  assert_neg_zero_res_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(p_sign) |-> res_o == '0);

  assert_zero_clean_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(p_mag) == '0) |-> (res_o == '0 && !invalid_o && !inexact_o));
endmodule

bind f64_to_u64_cvt cvt_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_cvt_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .rmode_i(rmode_i),
  .res_o(res_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
);

// File: tb/f64_to_u64_cvt_bench.sv
module f64_to_u64_cvt_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] op = '0;
  logic [1:0]  rm = 2'b00;
  logic [63:0] res;
  logic        inv, inx;
  int          n_checks = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  f64_to_u64_cvt u_f64_to_u64_cvt (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .rmode_i(rm),
    .res_o(res), .invalid_o(inv), .inexact_o(inx)
  );

  task automatic check(input logic [63:0] e_res, input logic e_inv, input logic e_inx,
                       input string tag);
    n_checks++;
    if (res !== e_res || inv !== e_inv || inx !== e_inx) begin
      n_fail++;
      $display("FAIL %s op=%h rm=%0d actual res=%h inv=%b inx=%b expected res=%h inv=%b inx=%b",
               tag, op, rm, res, inv, inx, e_res, e_inv, e_inx);
    end
  endtask

  // drive at a negedge, sample at the following negedge (one edge later)
  task automatic run(input logic [63:0] v, input logic [1:0] m,
                     input logic [63:0] e_res, input logic e_inv, input logic e_inx,
                     input string tag);
    op = v; rm = m;
    @(negedge clk);
    check(e_res, e_inv, e_inx, tag);
  endtask

  // integer reference: value = sig * 2^(e-1075)
  function automatic logic [65:0] ref_cvt(input logic [63:0] v, input logic [1:0] m);
    logic         s, nz, gt, tie, up;
    int           e, eu, k;
    logic [127:0] sig, ip, rem, half, r;
    s   = v[63];
    e   = int'(v[62:52]);
    sig = {76'd0, (e != 0), v[51:0]};
    eu  = (e == 0) ? 1 : e;
    if (s && e > 1022) return {64'd0, 1'b1, 1'b0};
    if (e > 1086)      return {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0};
    gt = 1'b0; tie = 1'b0;
    if (eu >= 1075) begin
      ip = sig << (eu - 1075); nz = 1'b0;
    end else begin
      k = 1075 - eu;
      if (k >= 100) begin
        ip = '0; nz = (sig != 0);
      end else begin
        ip   = sig >> k;
        rem  = sig - (ip << k);
        half = 128'd1 << (k - 1);
        nz   = (rem != 0);
        gt   = (rem > half);
        tie  = (rem == half);
      end
    end
    case (m)
      2'b00:   up = gt | (tie & ip[0]);
      2'b01:   up = s & nz;
      2'b10:   up = ~s & nz;
      default: up = 1'b0;
    endcase
    r = ip + 128'(up);
    if (s && r != 0) return {64'd0, 1'b1, 1'b0};
    return {r[63:0], 1'b0, nz};
  endfunction

  function automatic string sweep_tag(input logic [63:0] v, input logic [1:0] m, input logic nz);
    int e;
    e = int'(v[62:52]);
    if (v[63] && e > 1022) return "R3";
    if (e > 1086)          return "R4";
    if (v[63])             return "R10";
    if (!nz)               return "R5";
    case (m)
      2'b00:   return "R6";
      2'b01:   return "R9";
      2'b10:   return "R8";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [51:0] lf;
    logic [65:0] exp_v;
    logic [51:0] fr;
    logic [63:0] v;

    // R1: outputs held clear in reset even with a nonzero operand
    op = 64'h7FF0_0000_0000_0000; rm = 2'b00;
    repeat (3) @(negedge clk);
    check(64'd0, 1'b0, 1'b0, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R4 +inf");

    // R2: result only moves at the edge
    op = 64'h4014_0000_0000_0000; rm = 2'b11;  // 5.0
    #2;
    check(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R2 before edge");
    @(negedge clk);
    check(64'd5, 1'b0, 1'b0, "R2 after edge");

    // negative sub-unity patterns
    run(64'hBC6A_EEBA_7F39_0215, 2'b00, 64'd0, 1'b0, 1'b1, "R10 nearest");
    run(64'hA66A_44F2_52C9_AAAC, 2'b10, 64'd0, 1'b0, 1'b1, "R10 up");
    run(64'hB469_2F3A_FFAF_2716, 2'b01, 64'd0, 1'b1, 1'b0, "R9 R10 down");
    run(64'hBFE0_0000_0000_0000, 2'b00, 64'd0, 1'b0, 1'b1, "R10 -0.5 tie");
    run(64'hBFE0_0000_0000_0000, 2'b01, 64'd0, 1'b1, 1'b0, "R9 -0.5 down");
    run(64'hBFE8_0000_0000_0000, 2'b00, 64'd0, 1'b1, 1'b0, "R10 -0.75 nearest");

    // R3
    run(64'hBFF0_0000_0000_0000, 2'b11, 64'd0, 1'b1, 1'b0, "R3 -1.0");
    run(64'hFFF8_0000_0000_0000, 2'b00, 64'd0, 1'b1, 1'b0, "R3 -NaN");
    run(64'hFFF0_0000_0000_0000, 2'b10, 64'd0, 1'b1, 1'b0, "R3 -inf");

    // R4 / R5 boundary
    run(64'h43F0_0000_0000_0000, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R4 2^64");
    run(64'h7FF8_0000_0000_0001, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R4 NaN");
    for (int m = 0; m < 4; m++)
      run(64'h43EF_FFFF_FFFF_FFFF, 2'(m), 64'hFFFF_FFFF_FFFF_F800, 1'b0, 1'b0, "R5 top exponent");
    run(64'h4330_0000_0000_0001, 2'b00, 64'h0010_0000_0000_0001, 1'b0, 1'b0, "R5 2^52+1");

    // R6 ties and rounding
    run(64'h4004_0000_0000_0000, 2'b00, 64'd2, 1'b0, 1'b1, "R6 2.5");
    run(64'h400C_0000_0000_0000, 2'b00, 64'd4, 1'b0, 1'b1, "R6 3.5");
    run(64'h3FF8_0000_0000_0000, 2'b00, 64'd2, 1'b0, 1'b1, "R6 1.5");
    run(64'h3FE0_0000_0000_0000, 2'b00, 64'd0, 1'b0, 1'b1, "R6 0.5");
    run(64'h3FE0_0000_0000_0001, 2'b00, 64'd1, 1'b0, 1'b1, "R6 above half");
    // R7 R8 R9
    run(64'h3FF8_0000_0000_0000, 2'b11, 64'd1, 1'b0, 1'b1, "R7 1.5");
    run(64'h3FF8_0000_0000_0000, 2'b10, 64'd2, 1'b0, 1'b1, "R8 1.5");
    run(64'h3FF8_0000_0000_0000, 2'b01, 64'd1, 1'b0, 1'b1, "R9 1.5");

    // R12
    run(64'h0000_0000_0000_0000, 2'b10, 64'd0, 1'b0, 1'b0, "R12 +0");
    run(64'h8000_0000_0000_0000, 2'b01, 64'd0, 1'b0, 1'b0, "R12 -0");
    run(64'h0000_0000_0000_0001, 2'b00, 64'd0, 1'b0, 1'b1, "R12 subnormal nearest");
    run(64'h0000_0000_0000_0001, 2'b10, 64'd1, 1'b0, 1'b1, "R12 subnormal up");
    run(64'h8000_0000_0000_0001, 2'b01, 64'd0, 1'b1, 1'b0, "R12 R9 -subnormal down");

    // sweep: every exponent, both signs, all modes, several fractions (R11 on each)
    lf = 52'h5_A3C1_97E2_4B6D;
    for (int e = 0; e < 2048; e++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < 4; m++) begin
          for (int p = 0; p < 5; p++) begin
            case (p)
              0: fr = '0;
              1: fr = '1;
              2: fr = 52'h8_0000_0000_0000;
              3: fr = 52'h0_0000_0000_0001;
              default: begin
                lf = {lf[50:0], lf[51] ^ lf[48] ^ lf[2] ^ lf[0]};
                fr = lf;
              end
            endcase
            v = {1'(s), 11'(e), fr};
            exp_v = ref_cvt(v, 2'(m));
            run(v, 2'(m), exp_v[65:2], exp_v[1], exp_v[0],
                {sweep_tag(v, 2'(m), exp_v[0]), " R11 sweep"});
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule